// File: doc/BRIEF.md
# Performance State Controller with Thermal-Credit Boost

This block decides which performance state a core runs in. Software asks for one of several visible states, from the fastest (index 0) down to the slowest (the last index). Above these visible states sit two faster boost states. Only the hardware can grant a boost state, and software cannot name one. The block grants the deeper boost state when it has more stored credit and the shallower one when it has less.

A credit counter stands for the energy budget above the design power limit. At every sampled time tick the block compares the power sample with the limit. Credit grows while the core draws less than the limit and shrinks while it draws more. A boost state is granted only when software asks for the fastest visible state, enough credit has built up and the die is below its maximum temperature. When the die reaches that temperature, a failsafe throttle forces the slowest state at once. The throttle stays on until the die cools below a lower release point.

Top module: `pstate_boost_ctrl`

## Requirements
- R1: After reset the granted state is the slowest visible state (code NUM_SW+1), throttle is 0, credit is 0, and the first tick may change the state.
- R2: Granted-state codes are: 0 for the deeper boost state, 1 for the shallower boost state, and 2+k for visible state k. A software request k maps to code 2+k. Any request of NUM_SW-1 or higher maps to the slowest state.
- R3: At each tick the credit rises by (TDP_LIMIT - power) when power is below the limit and falls by (power - TDP_LIMIT) when power is above it. Credit is clamped to 0..CREDIT_MAX. Without a tick the credit does not change.
- R4: A boost state becomes the target only when all of these hold: the request is 0, throttle is off, temp is below TEMP_MAX, and credit is greater than ENTRY_THR. The target is code 0 when credit is at least PB0_THR and code 1 otherwise.
- R5: When the boost conditions no longer hold, the grant leaves boost for the requested visible state at the next tick that the dwell rule permits.
- R6: On the clock edge where temp is at least TEMP_MAX, throttle becomes 1 and the grant becomes the slowest state. This happens regardless of tick and dwell.
- R7: Throttle stays at 1 until temp is sampled below TEMP_HYST. While throttle is 1, the grant stays at the slowest state.
- R8: Apart from R6, the grant changes only on a tick edge, at most once per tick. After a change, at least DWELL_TICKS further ticks must pass before the next change.
- R9: Changing the request between ticks has no effect on the grant until a tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sampled time tick, one cycle wide |
| sw_req | input | REQ_W | Visible state requested by software |
| power | input | POWER_W | Power sample |
| temp | input | TEMP_W | Die temperature reading |
| grant_state | output | STATE_W | Granted state code (see R2) |
| throttle | output | 1 | Failsafe throttle active |

## Verification
The credit cannot be seen at the ports, so its saturation and its floor at zero can only be inferred from when boost starts and stops. The stimulus fills the credit to its maximum with many ticks at very low power. It then drains the credit with a fixed overdraw, so the tick on which boost exits depends on the clamped value. A second case heats the die while a boost state is granted. It then holds the temperature between the release point and the maximum across several ticks before cooling, which exercises the throttle hysteresis together with the dwell rule.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int PB0_CODE = 0;
  localparam int PB1_CODE = 1;
  localparam int SW_BASE  = 2;
endpackage

// File: rtl/pbc_credit.sv
module pbc_credit #(
  parameter int CREDIT_W   = 12,
  parameter int POWER_W    = 8,
  parameter int CREDIT_MAX = 2000,
  parameter int TDP_LIMIT  = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [POWER_W-1:0]  power,
  output logic [CREDIT_W-1:0] credit_q
);
  localparam int EW = ((CREDIT_W > POWER_W) ? CREDIT_W : POWER_W) + 2;

  logic [EW-1:0]       cur, pw, lim, delta, sum;
  logic [CREDIT_W-1:0] credit_d;
  logic                credit_en;

  always_comb begin
    cur   = EW'(credit_q);
    pw    = EW'(power);
    lim   = EW'(TDP_LIMIT);
    delta = '0;
    sum   = cur;
    if (pw < lim) begin
      delta = lim - pw;
      sum   = cur + delta;
      if (sum > EW'(CREDIT_MAX)) sum = EW'(CREDIT_MAX);
    end else begin
      delta = pw - lim;
      if (delta >= cur) sum = '0;
      else              sum = cur - delta;
    end
    credit_en = tick;
    credit_d  = sum[CREDIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         credit_q <= '0;
    else if (credit_en) credit_q <= credit_d;
  end
endmodule

// File: rtl/pbc_thermal.sv
module pbc_thermal #(
  parameter int TEMP_W    = 8,
  parameter int TEMP_MAX  = 100,
  parameter int TEMP_HYST = 85
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp,
  output logic              hot_now,
  output logic              throttle_q
);
  logic thr_en, thr_d;

  always_comb begin
    hot_now = (temp >= TEMP_W'(TEMP_MAX));
    thr_en  = hot_now || (temp < TEMP_W'(TEMP_HYST));
    thr_d   = hot_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      throttle_q <= 1'b0;
    else if (thr_en) throttle_q <= thr_d;
  end
endmodule

// File: rtl/pbc_state_sel.sv
module pbc_state_sel
  import pbc_pkg::*;
#(
  parameter int NUM_SW      = 5,
  parameter int REQ_W       = 3,
  parameter int STATE_W     = 3,
  parameter int CREDIT_W    = 12,
  parameter int ENTRY_THR   = 200,
  parameter int PB0_THR     = 1000,
  parameter int DWELL_TICKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [REQ_W-1:0]    sw_req,
  input  logic [CREDIT_W-1:0] credit,
  input  logic                hot_now,
  input  logic                throttle_q,
  output logic [STATE_W-1:0]  grant_q
);
  localparam int DW_W      = $clog2(DWELL_TICKS + 2);
  localparam int PMIN_CODE = SW_BASE + NUM_SW - 1;

  logic [STATE_W-1:0] req_code, target, grant_d;
  logic [DW_W-1:0]    dwell_q, dwell_d;
  logic               boost_ok, dwell_ok, grant_en, dwell_en;

  always_comb begin
    if (sw_req >= REQ_W'(NUM_SW - 1)) req_code = STATE_W'(PMIN_CODE);
    else                              req_code = STATE_W'(SW_BASE) + STATE_W'(sw_req);

    boost_ok = !throttle_q && !hot_now && (sw_req == '0) &&
               (credit > CREDIT_W'(ENTRY_THR));

    if (throttle_q || hot_now)
      target = STATE_W'(PMIN_CODE);
    else if (boost_ok)
      target = (credit >= CREDIT_W'(PB0_THR)) ? STATE_W'(PB0_CODE) : STATE_W'(PB1_CODE);
    else
      target = req_code;

    dwell_ok = (dwell_q >= DW_W'(DWELL_TICKS));
    grant_en = 1'b0;
    grant_d  = grant_q;
    dwell_en = 1'b0;
    dwell_d  = dwell_q;
    if (hot_now && (grant_q != STATE_W'(PMIN_CODE))) begin
      grant_en = 1'b1;
      grant_d  = STATE_W'(PMIN_CODE);
      dwell_en = 1'b1;
      dwell_d  = '0;
    end else if (tick) begin
      if (dwell_ok && (target != grant_q)) begin
        grant_en = 1'b1;
        grant_d  = target;
        dwell_en = 1'b1;
        dwell_d  = '0;
      end else if (!dwell_ok) begin
        dwell_en = 1'b1;
        dwell_d  = dwell_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= STATE_W'(PMIN_CODE);
      dwell_q <= DW_W'(DWELL_TICKS);
    end else begin
      if (grant_en) grant_q <= grant_d;
      if (dwell_en) dwell_q <= dwell_d;
    end
  end
endmodule

// File: rtl/pstate_boost_ctrl.sv
module pstate_boost_ctrl #(
  parameter int NUM_SW      = 5,
  parameter int REQ_W       = 3,
  parameter int CREDIT_W    = 12,
  parameter int CREDIT_MAX  = 2000,
  parameter int POWER_W     = 8,
  parameter int TDP_LIMIT   = 100,
  parameter int TEMP_W      = 8,
  parameter int TEMP_MAX    = 100,
  parameter int TEMP_HYST   = 85,
  parameter int ENTRY_THR   = 200,
  parameter int PB0_THR     = 1000,
  parameter int DWELL_TICKS = 4,
  localparam int STATE_W    = $clog2(NUM_SW + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [REQ_W-1:0]   sw_req,
  input  logic [POWER_W-1:0] power,
  input  logic [TEMP_W-1:0]  temp,
  output logic [STATE_W-1:0] grant_state,
  output logic               throttle
);
  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic [CREDIT_W-1:0] credit_q;
  logic                hot_now, throttle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pbc_credit #(
    .CREDIT_W(CREDIT_W), .POWER_W(POWER_W),
    .CREDIT_MAX(CREDIT_MAX), .TDP_LIMIT(TDP_LIMIT)
  ) u_credit (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .power(power), .credit_q(credit_q)
  );

  pbc_thermal #(
    .TEMP_W(TEMP_W), .TEMP_MAX(TEMP_MAX), .TEMP_HYST(TEMP_HYST)
  ) u_thermal (
    .clk(clk), .rst_n(rst_sync_n), .temp(temp), .hot_now(hot_now), .throttle_q(throttle_q)
  );

  pbc_state_sel #(
    .NUM_SW(NUM_SW), .REQ_W(REQ_W), .STATE_W(STATE_W), .CREDIT_W(CREDIT_W),
    .ENTRY_THR(ENTRY_THR), .PB0_THR(PB0_THR), .DWELL_TICKS(DWELL_TICKS)
  ) u_sel (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .sw_req(sw_req), .credit(credit_q),
    .hot_now(hot_now), .throttle_q(throttle_q), .grant_q(grant_state)
  );

  assign throttle = throttle_q;
endmodule

// File: rtl/pstate_boost_ctrl_chk.sv
module pstate_boost_ctrl_chk #(
  parameter int NUM_SW     = 5,
  parameter int REQ_W      = 3,
  parameter int STATE_W    = 3,
  parameter int CREDIT_W   = 12,
  parameter int CREDIT_MAX = 2000,
  parameter int TEMP_W     = 8,
  parameter int TEMP_MAX   = 100
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [REQ_W-1:0]   sw_req,
  input logic [TEMP_W-1:0]  temp,
  input logic [STATE_W-1:0] grant_state,
  input logic               throttle,
  input logic [CREDIT_W-1:0] credit
);
  localparam int PMIN = NUM_SW + 1;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r3_credit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CREDIT_W'(CREDIT_MAX));

  a_r3_credit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(tick)) |-> $stable(credit));

  a_r4_boost_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && grant_state < STATE_W'(2) && grant_state != $past(grant_state)) |->
    ($past(sw_req) == '0 && $past(temp) < TEMP_W'(TEMP_MAX) && !$past(throttle)));

  a_r6_hot_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(temp) >= TEMP_W'(TEMP_MAX)) |-> (throttle && grant_state == STATE_W'(PMIN)));

  a_r7_throttle_pmin: assert property (@(posedge clk) disable iff (!rst_n)
    throttle |-> grant_state == STATE_W'(PMIN));

  a_r8_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && grant_state != $past(grant_state)) |->
    ($past(tick) || $past(temp) >= TEMP_W'(TEMP_MAX)));
endmodule

bind pstate_boost_ctrl pstate_boost_ctrl_chk #(
  .NUM_SW(NUM_SW), .REQ_W(REQ_W), .STATE_W(STATE_W), .CREDIT_W(CREDIT_W),
  .CREDIT_MAX(CREDIT_MAX), .TEMP_W(TEMP_W), .TEMP_MAX(TEMP_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .sw_req(sw_req), .temp(temp),
  .grant_state(grant_state), .throttle(throttle), .credit(credit_q)
);

// File: tb/pstate_boost_ctrl_tb.sv
module pstate_boost_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSW = 5, RQW = 3, CW = 10, CMAX = 200, PW = 8, TDP = 100;
  localparam int TW = 8, TMAX = 95, THYST = 80, ENTRY = 40, PB0 = 120, DW = 2;
  localparam int SW = $clog2(NSW + 2);
  localparam int PMIN = NSW + 1;

  typedef struct { int grant; int thr; string tag; } exp_t;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [RQW-1:0] sw_req = 3'd4;
  logic [PW-1:0]  power = 8'd100;
  logic [TW-1:0]  temp = 8'd25;
  logic [SW-1:0]  grant_state;
  logic           throttle;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t q[$];
  int m_credit = 0, m_grant = PMIN, m_thr = 0, m_dwell = DW;

  always #(CLK_PERIOD/2) clk = ~clk;

  pstate_boost_ctrl #(
    .NUM_SW(NSW), .REQ_W(RQW), .CREDIT_W(CW), .CREDIT_MAX(CMAX), .POWER_W(PW),
    .TDP_LIMIT(TDP), .TEMP_W(TW), .TEMP_MAX(TMAX), .TEMP_HYST(THYST),
    .ENTRY_THR(ENTRY), .PB0_THR(PB0), .DWELL_TICKS(DW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_req(sw_req), .power(power),
    .temp(temp), .grant_state(grant_state), .throttle(throttle)
  );

  task automatic step(input int r, input int p, input int t, input bit k, input string tag);
    int tgt, ng, nd, nc, nt;
    bit hot;
    exp_t e;
    @(negedge clk);
    sw_req = RQW'(r); power = PW'(p); temp = TW'(t); tick = k;
    hot = (t >= TMAX);
    if (m_thr != 0 || hot) tgt = PMIN;
    else if (r == 0 && m_credit > ENTRY) tgt = (m_credit >= PB0) ? 0 : 1;
    else tgt = (r >= NSW - 1) ? PMIN : 2 + r;
    ng = m_grant; nd = m_dwell;
    if (hot && m_grant != PMIN) begin ng = PMIN; nd = 0; end
    else if (k) begin
      if (m_dwell >= DW && tgt != m_grant) begin ng = tgt; nd = 0; end
      else if (m_dwell < DW) nd = m_dwell + 1;
    end
    nc = m_credit;
    if (k) begin
      if (p < TDP) begin nc = m_credit + TDP - p; if (nc > CMAX) nc = CMAX; end
      else begin nc = m_credit - (p - TDP); if (nc < 0) nc = 0; end
    end
    nt = hot ? 1 : ((t < THYST) ? 0 : m_thr);
    m_grant = ng; m_dwell = nd; m_credit = nc; m_thr = nt;
    e.grant = ng; e.thr = nt; e.tag = tag;
    q.push_back(e);
  endtask

  // one tick followed by one quiet cycle
  task automatic tk(input int r, input int p, input int t, input string tag);
    step(r, p, t, 1'b1, tag);
    step(r, p, t, 1'b0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_cmp++;
        if (int'(grant_state) != e.grant || int'(throttle) != e.thr) begin
          n_bad++;
          $display("FAIL %s: grant=%0d thr=%0d expected grant=%0d thr=%0d",
                   e.tag, grant_state, throttle, e.grant, e.thr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (int'(grant_state) != PMIN || throttle !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: grant=%0d thr=%0d expected grant=%0d thr=0", grant_state, throttle, PMIN);
    end
    // R2 request mapping, R8 dwell between changes
    tk(1, 100, 25, "R2 request P1");
    tk(2, 100, 25, "R8 dwell blocks");
    tk(2, 100, 25, "R8 dwell blocks");
    tk(2, 100, 25, "R2 request P2");
    repeat (3) tk(7, 100, 25, "R2 out of range to Pmin");
    repeat (3) tk(0, 100, 25, "R4 no credit no boost");
    // R9 request changes without tick
    step(3, 100, 25, 1'b0, "R9 no tick");
    step(1, 100, 25, 1'b0, "R9 no tick");
    step(4, 40, 25, 1'b0, "R9 R3 no tick no credit");
    step(0, 40, 25, 1'b0, "R9 no tick");
    // R3 R4 accumulate credit, boost Pb1 then Pb0
    repeat (6) tk(0, 40, 25, "R4 R3 boost build");
    // R3 saturation then drain, R5 exit
    repeat (6) tk(2, 0, 25, "R3 saturate");
    repeat (3) tk(0, 100, 25, "R4 saturated boost");
    repeat (6) tk(0, 150, 25, "R5 R3 drain exit");
    repeat (3) tk(0, 250, 25, "R3 floor zero");
    repeat (3) tk(0, 100, 25, "R3 floor zero no boost");
    // R6 R7 throttle during boost with hysteresis
    repeat (6) tk(0, 20, 25, "R4 rebuild");
    step(0, 20, 99, 1'b0, "R6 hot forces Pmin");
    repeat (4) tk(0, 20, 90, "R7 held in band");
    tk(0, 20, 96, "R6 hot on tick");
    tk(0, 20, 79, "R7 release");
    repeat (4) tk(0, 20, 79, "R5 return after cool");
    // R8 fast alternating requests
    for (int i = 0; i < 8; i++) tk((i % 2 == 0) ? 3 : 1, 100, 25, "R8 alternate");
    repeat (3) step(2, 100, 25, 1'b0, "R9 tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule